// File: doc/BRIEF.md
# Four-Channel PWM Generator with Break Override

This block produces four pulse-width-modulated outputs from a single 12-bit counter that runs freely and wraps. Each channel holds a 12-bit duty value. Its output is high while the counter is below that value, so the number of high cycles in each 4096-cycle period equals the duty value. Software programs the duty values, a per-channel output enable and a break configuration through a byte-wide port. Writes take effect on a clock edge and reads return data in the same cycle.

A break pin with selectable polarity can stop normal modulation. The pin is synchronized and compared against the chosen active level. When it matches and the pin is enabled, a sticky break flag is set. While the flag is set, every enabled output shows its bit of a programmable 4-bit safe pattern in place of its PWM value. Software can also set or clear the flag. A clear has no effect while the enabled pin is still at its active level.

Top module: `pwm_break_unit`

## Requirements
- R1: After reset, every register reads 0 and all four outputs are low.
- R2: The counter is 12 bits wide, advances by one every clock and wraps from 0xFFF to 0. A channel with duty 1 is therefore high for one cycle every 4096 cycles.
- R3: An enabled channel is high exactly while counter < duty. Over any 4096 consecutive cycles it is high for `duty` cycles, and a duty of 0 keeps it low.
- R4: Register map. Address 0 holds the output enables in bits 3:0, with bit i for channel i. Address 1 is the break register. Address 2+2i holds duty bits 7:0 of channel i. Address 3+2i holds duty bits 11:8 in bits 3:0, and bits 7:4 of that register always read 0. Any unmapped address reads 0.
- R5: A channel whose enable bit is 0 stays low, whatever its duty and whatever the break state.
- R6: Break register bit 4 is the pin enable. With it set, the flag (break register bit 5) goes to 1 on the third rising edge after the pin reaches its active level, once the signal has passed two synchronizer stages.
- R7: Break register bit 6 selects the active level of the pin: 1 makes high active and 0 makes low active.
- R8: While the pin enable is 0, the pin has no effect on the flag.
- R9: Writing bit 5 of the break register sets or clears the flag. A clear written while the enabled pin is at its active level leaves the flag at 1.
- R10: While the flag is 1, each enabled output i equals bit i of the pattern held in break register bits 3:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, captured on the rising edge |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, valid in the same cycle |
| brk_pin | input | 1 | Asynchronous break request |
| pwm_out | output | 4 | PWM outputs, bit i for channel i |

## Verification
The hardest case to reach is a software clear of the flag that arrives while the synchronized pin is still at its active level. The stimulus holds the pin active, waits until the flag has been set through the synchronizer, and then writes the break register with bit 5 at 0. It confirms that the flag stays set, then releases the pin and repeats the clear. The edge-exact latency through the synchronizer is checked by reading the flag back after two edges and again after three edges.

// File: rtl/pwmbrk_pkg.sv
package pwmbrk_pkg;
  localparam int CNT_W   = 12;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int NCH     = 4;

  localparam int ADR_OE     = 0;
  localparam int ADR_BRK    = 1;
  localparam int ADR_DUTY0  = 2;

  // break register field positions
  localparam int BRK_PAT_LSB = 0;
  localparam int BRK_PIN_EN  = 4;
  localparam int BRK_FLAG    = 5;
  localparam int BRK_LEVEL   = 6;

  typedef struct packed {
    logic           level;
    logic           pin_en;
    logic [NCH-1:0] pattern;
  } brk_cfg_t;
endpackage

// File: rtl/pwmbrk_counter.sv
module pwmbrk_counter #(
  parameter int CNT_W = pwmbrk_pkg::CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/pwmbrk_channel.sv
module pwmbrk_channel #(
  parameter int CNT_W  = pwmbrk_pkg::CNT_W,
  parameter int DATA_W = pwmbrk_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  output logic [CNT_W-1:0]  duty,
  output logic              pwm
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [CNT_W-1:0] duty_q, duty_d;
  logic             duty_en;

  always_comb begin
    duty_d  = duty_q;
    duty_en = wr_lo | wr_hi;
    if (wr_lo) duty_d[DATA_W-1:0]     = wdata;
    if (wr_hi) duty_d[CNT_W-1:DATA_W] = wdata[HI_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       duty_q <= '0;
    else if (duty_en) duty_q <= duty_d;
  end

  assign duty = duty_q;
  assign pwm  = (cnt < duty_q);
endmodule

// File: rtl/pwmbrk_break.sv
module pwmbrk_break #(
  parameter int NCH    = pwmbrk_pkg::NCH,
  parameter int DATA_W = pwmbrk_pkg::DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 brk_pin,
  input  logic                 wr,
  input  logic [DATA_W-1:0]    wdata,
  output pwmbrk_pkg::brk_cfg_t cfg,
  output logic                 flag,
  output logic                 hit
);
  import pwmbrk_pkg::*;

  logic [1:0] sync_q;
  brk_cfg_t   cfg_q, cfg_d;
  logic       flag_q, flag_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], brk_pin};
  end

  assign hit = cfg_q.pin_en & (sync_q[1] == cfg_q.level);

  always_comb begin
    cfg_d.level   = wdata[BRK_LEVEL];
    cfg_d.pin_en  = wdata[BRK_PIN_EN];
    cfg_d.pattern = wdata[BRK_PAT_LSB +: NCH];
    if (hit)     flag_d = 1'b1;
    else if (wr) flag_d = wdata[BRK_FLAG];
    else         flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= '0;
    else if (wr) cfg_q <= cfg_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign cfg  = cfg_q;
  assign flag = flag_q;
endmodule

// File: rtl/pwm_break_unit.sv
module pwm_break_unit #(
  parameter int CNT_W  = pwmbrk_pkg::CNT_W,
  parameter int DATA_W = pwmbrk_pkg::DATA_W,
  parameter int ADDR_W = pwmbrk_pkg::ADDR_W,
  parameter int NCH    = pwmbrk_pkg::NCH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              brk_pin,
  output logic [NCH-1:0]    pwm_out
);
  import pwmbrk_pkg::*;

  localparam int HI_W = CNT_W - DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  logic [CNT_W-1:0]            cnt;
  logic [NCH-1:0][CNT_W-1:0]   duty;
  logic [NCH-1:0]              pwm_raw;
  logic [NCH-1:0]              oe_q, oe_d;
  logic                        wr_oe, wr_brk;
  brk_cfg_t                    brk_cfg;
  logic                        brk_flag, brk_hit;

  assign wr_oe  = wr_en && (addr == ADDR_W'(ADR_OE));
  assign wr_brk = wr_en && (addr == ADDR_W'(ADR_BRK));

  pwmbrk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .cnt(cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int ADR_LO = ADR_DUTY0 + 2 * i;
    logic wr_lo, wr_hi;
    assign wr_lo = wr_en && (addr == ADDR_W'(ADR_LO));
    assign wr_hi = wr_en && (addr == ADDR_W'(ADR_LO + 1));
    pwmbrk_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n_i), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .wdata(wdata), .cnt(cnt), .duty(duty[i]), .pwm(pwm_raw[i])
    );
  end

  pwmbrk_break #(.NCH(NCH), .DATA_W(DATA_W)) u_brk (
    .clk(clk), .rst_n(rst_n_i), .brk_pin(brk_pin), .wr(wr_brk),
    .wdata(wdata), .cfg(brk_cfg), .flag(brk_flag), .hit(brk_hit)
  );

  always_comb begin
    oe_d = wdata[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)   oe_q <= '0;
    else if (wr_oe) oe_q <= oe_d;
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(ADR_OE)) rdata[NCH-1:0] = oe_q;
    if (addr == ADDR_W'(ADR_BRK)) begin
      rdata[BRK_PAT_LSB +: NCH] = brk_cfg.pattern;
      rdata[BRK_PIN_EN]         = brk_cfg.pin_en;
      rdata[BRK_FLAG]           = brk_flag;
      rdata[BRK_LEVEL]          = brk_cfg.level;
    end
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(ADR_DUTY0 + 2 * i))
        rdata = duty[i][DATA_W-1:0];
      if (addr == ADDR_W'(ADR_DUTY0 + 2 * i + 1))
        rdata = {{(DATA_W-HI_W){1'b0}}, duty[i][CNT_W-1:DATA_W]};
    end
  end

  always_comb begin
    pwm_out = oe_q & (brk_flag ? brk_cfg.pattern : pwm_raw);
  end
endmodule

// File: rtl/pwm_break_unit_chk.sv
module pwm_break_unit_chk #(
  parameter int CNT_W  = pwmbrk_pkg::CNT_W,
  parameter int DATA_W = pwmbrk_pkg::DATA_W,
  parameter int ADDR_W = pwmbrk_pkg::ADDR_W,
  parameter int NCH    = pwmbrk_pkg::NCH
) (
  input logic                      clk,
  input logic                      rst_n_i,
  input logic [CNT_W-1:0]          cnt,
  input logic [NCH-1:0][CNT_W-1:0] duty,
  input logic [NCH-1:0]            pwm_raw,
  input logic                      brk_flag,
  input logic                      brk_hit,
  input logic                      wr_brk,
  input logic [DATA_W-1:0]         wdata,
  input logic [ADDR_W-1:0]         addr,
  input logic [DATA_W-1:0]         rdata,
  input logic                      brk_pin,
  input pwmbrk_pkg::brk_cfg_t      brk_cfg
);
  import pwmbrk_pkg::*;

  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i)            cyc_q <= '0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 1'b1;
  end

  logic hi_addr;
  assign hi_addr = (addr >= ADDR_W'(ADR_DUTY0)) &&
                   (addr <= ADDR_W'(ADR_DUTY0 + 2 * NCH - 1)) && addr[0];

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cyc_q != 2'd0) |-> cnt == CNT_W'($past(cnt) + 1'b1));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R3
    duty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
      (duty[i] == '0) |-> !pwm_raw[i]);
  end

  // R4
  rsvd_read_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    hi_addr |-> rdata[DATA_W-1:CNT_W-DATA_W] == '0);

  // R6
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cyc_q == 2'd3 && $rose(brk_flag) && !$past(wr_brk)) |->
      ($past(brk_cfg.pin_en) && ($past(brk_pin, 3) == $past(brk_cfg.level))));

  // R9
  hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (brk_hit && wr_brk && !wdata[BRK_FLAG]) |=> brk_flag);
endmodule

bind pwm_break_unit pwm_break_unit_chk #(
  .CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NCH(NCH)
) u_chk (
  .clk(clk), .rst_n_i(rst_n_i), .cnt(cnt), .duty(duty), .pwm_raw(pwm_raw),
  .brk_flag(brk_flag), .brk_hit(brk_hit), .wr_brk(wr_brk), .wdata(wdata),
  .addr(addr), .rdata(rdata), .brk_pin(brk_pin), .brk_cfg(brk_cfg)
);

// File: tb/pwm_break_unit_test.sv
module pwm_break_unit_test;
  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [3:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       brk_pin;
  logic [3:0] pwm_out;

  int n_chk;
  int n_fail;
  bit done;

  pwm_break_unit uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .brk_pin(brk_pin), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {channel[1:0], duty[11:0], expected high cycles per period[12:0]}
  localparam logic [26:0] VEC [0:4] = '{
    {2'd0, 12'h000, 13'd0},
    {2'd1, 12'h001, 13'd1},
    {2'd2, 12'h800, 13'd2048},
    {2'd3, 12'hFFF, 13'd4095},
    {2'd0, 12'h123, 13'd291}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    #2 v = rdata;
  endtask

  task automatic set_duty(input int ch, input logic [11:0] d);
    wr(4'(3 + 2 * ch), {4'h0, d[11:8]});
    wr(4'(2 + 2 * ch), d[7:0]);
  endtask

  task automatic count_high(input int ch, output int n);
    n = 0;
    for (int k = 0; k < 4096; k++) begin
      @(negedge clk);
      if (pwm_out[ch]) n++;
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n;
    rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0; brk_pin = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state and R4 unmapped reads
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      check(v == 8'h00, "R1", v, 0);
    end
    check(pwm_out == 4'h0, "R1", pwm_out, 0);

    // R3 vector table
    wr(4'h0, 8'h0F);
    for (int i = 0; i < 5; i++) begin
      set_duty(int'(VEC[i][26:25]), VEC[i][24:13]);
      count_high(int'(VEC[i][26:25]), n);
      check(n == int'(VEC[i][12:0]), "R3", n, int'(VEC[i][12:0]));
    end
    for (int c = 0; c < 4; c++) set_duty(c, 12'h000);
    wait_cyc(2);
    check(pwm_out == 4'h0, "R3", pwm_out, 0);

    // R4 reserved bits and readback
    wr(4'h7, 8'hFF);
    rd(4'h7, v);
    check(v == 8'h0F, "R4", v, 8'h0F);
    wr(4'h6, 8'hAB);
    rd(4'h6, v);
    check(v == 8'hAB, "R4", v, 8'hAB);
    rd(4'hC, v);
    check(v == 8'h00, "R4", v, 0);
    set_duty(2, 12'h000);

    // R2 period of 4096 with duty 1
    set_duty(0, 12'h001);
    n = 0;
    while (!pwm_out[0] && n < 5000) begin @(negedge clk); n++; end
    @(negedge clk);
    check(!pwm_out[0], "R2", pwm_out[0], 0);
    n = 1;
    while (!pwm_out[0] && n < 5000) begin @(negedge clk); n++; end
    check(n == 4096, "R2", n, 4096);
    set_duty(0, 12'h000);

    // R8 pin ignored when not enabled
    wr(4'h1, 8'h4A);
    brk_pin = 1'b1;
    wait_cyc(6);
    rd(4'h1, v);
    check(v == 8'h4A, "R8", v, 8'h4A);
    check(pwm_out == 4'h0, "R8", pwm_out, 0);

    // R6 latency, R7 high active, R10 pattern
    brk_pin = 1'b0;
    wait_cyc(3);
    wr(4'h1, 8'h5A);
    addr = 4'h1;
    brk_pin = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    #2 check(rdata[5] == 1'b0, "R6", rdata[5], 0);
    check(pwm_out == 4'h0, "R6", pwm_out, 0);
    @(posedge clk); @(negedge clk);
    #2 check(rdata[5] == 1'b1, "R6", rdata[5], 1);
    check(pwm_out == 4'hA, "R10", pwm_out, 4'hA);

    // R9 clear blocked while pin active, then allowed
    wr(4'h1, 8'h5A);
    rd(4'h1, v);
    check(v == 8'h7A, "R9", v, 8'h7A);
    brk_pin = 1'b0;
    wait_cyc(3);
    wr(4'h1, 8'h5A);
    rd(4'h1, v);
    check(v == 8'h5A, "R9", v, 8'h5A);
    check(pwm_out == 4'h0, "R9", pwm_out, 0);

    // R7 low active
    wr(4'h1, 8'h13);
    wait_cyc(3);
    rd(4'h1, v);
    check(v == 8'h33, "R7", v, 8'h33);
    check(pwm_out == 4'h3, "R10", pwm_out, 4'h3);
    brk_pin = 1'b1;
    wait_cyc(4);
    wr(4'h1, 8'h13);
    wait_cyc(4);
    rd(4'h1, v);
    check(v == 8'h13, "R7", v, 8'h13);

    // R5 disabled channels stay low, R9 software set
    wr(4'h0, 8'h05);
    wr(4'h1, 8'h2F);
    wait_cyc(1);
    check(pwm_out == 4'h5, "R5", pwm_out, 4'h5);
    wr(4'h1, 8'h0F);
    set_duty(1, 12'h800);
    count_high(1, n);
    check(n == 0, "R5", n, 0);
    check(pwm_out[0] == 1'b0, "R9", pwm_out[0], 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule